// File: doc/BRIEF.md
# Two-Space Paged Copy Engine

This block moves a run of bytes from one place in memory to another. The source and the destination each carry their own address-space index, so reads and writes can target different translation contexts. A caller pulses `start` with the two addresses, the two space indices, a byte count and an addressing mode. The engine then copies the data in ascending order and pulses `done` when the count is used up.

The copy goes in steps. At the start of each step both current addresses are folded into the active addressing mode (24-bit, 31-bit or 64-bit), and the folded addresses are shown on two lookup ports. The outside world answers on those ports whether each page is directly mapped. If both pages are mapped, the step moves as many bytes as it can: the remaining count, cut down to the room left in the source page and then to the room left in the destination page. This step is one read burst into an internal page-sized staging RAM, followed by one write burst from it. If either page is not mapped, the step moves exactly one byte. A single memory port with per-beat request/grant carries both the reads and the writes.

Top module: `xspace_copy_engine`

## Requirements
- R1: With `addr_mode` = 0 (24-bit), every lookup address and every memory beat address has all bits above bit 23 cleared, and an address that steps past 2^24-1 wraps to 0 before the next step.
- R2: With `addr_mode` = 1 (31-bit), every lookup and beat address has all bits above bit 30 cleared, and stepping past 2^31-1 wraps to 0.
- R3: With `addr_mode` = 2 or 3 (64-bit), addresses pass through unmodified, high bits included.
- R4: When both lookups report mapped, a step is one read burst followed by one write burst, each of N beats with `mem_burst`=1 and `mem_len`=N. N is the remaining count, limited to 4096 minus source address bits [11:0] and then to 4096 minus destination address bits [11:0], so no burst crosses a 4096-byte page.
- R5: When either lookup reports unmapped, the step is one read beat and one write beat with `mem_burst`=0 and `mem_len`=1.
- R6: Read beats (`mem_we`=0) carry the source space index and write beats (`mem_we`=1) carry the destination space index. The two are independent.
- R7: Each destination byte receives the source byte at the same offset. Beats go in strictly ascending address order per burst, reads of a step finish before its writes start, and `done` is a single-cycle pulse with `busy` low in that cycle.
- R8: A start with `length` = 0 raises `done` on the cycle after start and issues no memory request and no lookup.
- R9: `look_en` is high for exactly one cycle before each step, with `src_look_addr`/`dst_look_addr` holding the folded current addresses and the look space ports holding the two space indices.
- R10: A `start` pulse while `busy` is high is ignored; the running copy's beats are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a copy (taken only when idle) |
| src_addr | input | 64 | Source start address |
| dst_addr | input | 64 | Destination start address |
| length | input | 32 | Byte count |
| src_space | input | 2 | Source address-space index |
| dst_space | input | 2 | Destination address-space index |
| addr_mode | input | 2 | 0: 24-bit, 1: 31-bit, 2/3: 64-bit |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| look_en | output | 1 | Lookup strobe, one cycle per step |
| src_look_addr | output | 64 | Folded source address being looked up |
| src_look_space | output | 2 | Source space for the lookup |
| src_mapped | input | 1 | Source page directly mapped (sampled while look_en) |
| dst_look_addr | output | 64 | Folded destination address being looked up |
| dst_look_space | output | 2 | Destination space for the lookup |
| dst_mapped | input | 1 | Destination page directly mapped (sampled while look_en) |
| mem_req | output | 1 | Beat request |
| mem_we | output | 1 | 1 write beat, 0 read beat |
| mem_addr | output | 64 | Beat byte address |
| mem_space | output | 2 | Space index for the beat |
| mem_len | output | 13 | Beats in the current burst |
| mem_burst | output | 1 | Current step is a burst step |
| mem_wdata | output | 8 | Write byte |
| mem_gnt | input | 1 | Beat accepted on this edge |
| mem_rdata | input | 8 | Read byte, valid with mem_gnt |

## Verification
Two cases are hard to reach from the ports. The first is a mode wrap in the middle of a copy, where an address steps off the top of the 24-bit or 31-bit range. The bench reaches it by starting the source a few bytes below the boundary with high garbage bits set, so the first burst ends exactly at the boundary and the next lookup must show address zero. The second is a step pattern that mixes bursts with single bytes. The bench's mapping model marks every page with address bit 12 set as unmapped, so one copy crosses from a mapped page into an unmapped one. The grant is held back in a pseudo-random pattern throughout, so every beat sequence is also checked under stalls.

// File: rtl/xcopy_pkg.sv
package xcopy_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOOK  = 3'd1,
    ST_READ  = 3'd2,
    ST_WPREP = 3'd3,
    ST_WRITE = 3'd4
  } xc_state_e;

  localparam logic [1:0] MODE_A24 = 2'd0;
  localparam logic [1:0] MODE_A31 = 2'd1;

endpackage

// File: rtl/xcopy_addr_wrap.sv
module xcopy_addr_wrap #(
  parameter int AW = 64
) (
  input  logic [1:0]    mode,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out
);
  import xcopy_pkg::*;

  always_comb begin
    addr_out = addr_in;
    case (mode)
      MODE_A24: addr_out[AW-1:24] = '0;
      MODE_A31: addr_out[AW-1:31] = '0;
      default:  addr_out = addr_in;
    endcase
  end

endmodule

// File: rtl/xcopy_chunk_calc.sv
module xcopy_chunk_calc #(
  parameter int LW     = 32,
  parameter int PAGE_W = 12
) (
  input  logic [LW-1:0]     rem,
  input  logic [PAGE_W-1:0] src_off,
  input  logic [PAGE_W-1:0] dst_off,
  input  logic              src_ok,
  input  logic              dst_ok,
  output logic [PAGE_W:0]   chunk,
  output logic              burst
);
  localparam int CW = PAGE_W + 1;
  localparam logic [CW-1:0] PAGE_C = {1'b1, {PAGE_W{1'b0}}};

  logic [CW-1:0] room_s;
  logic [CW-1:0] room_d;
  logic [CW-1:0] room;

  always_comb begin
    room_s = PAGE_C - {1'b0, src_off};
    room_d = PAGE_C - {1'b0, dst_off};
    room   = (room_d < room_s) ? room_d : room_s;
    burst  = src_ok && dst_ok;
    if (!burst) begin
      chunk = CW'(1);
    end else if (rem < LW'(room)) begin
      chunk = rem[CW-1:0];
    end else begin
      chunk = room;
    end
  end

endmodule

// File: rtl/xcopy_stage_buf.sv
module xcopy_stage_buf #(
  parameter int DW     = 8,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) ram[wr_addr] <= wr_data;
    rd_data <= ram[rd_addr];
  end

endmodule

// File: rtl/xspace_copy_engine.sv
module xspace_copy_engine #(
  parameter int AW     = 64,
  parameter int LW     = 32,
  parameter int PAGE_W = 12,
  parameter int SPW    = 2,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [AW-1:0]     src_addr,
  input  logic [AW-1:0]     dst_addr,
  input  logic [LW-1:0]     length,
  input  logic [SPW-1:0]    src_space,
  input  logic [SPW-1:0]    dst_space,
  input  logic [1:0]        addr_mode,
  output logic              busy,
  output logic              done,
  output logic              look_en,
  output logic [AW-1:0]     src_look_addr,
  output logic [SPW-1:0]    src_look_space,
  input  logic              src_mapped,
  output logic [AW-1:0]     dst_look_addr,
  output logic [SPW-1:0]    dst_look_space,
  input  logic              dst_mapped,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [SPW-1:0]    mem_space,
  output logic [PAGE_W:0]   mem_len,
  output logic              mem_burst,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_gnt,
  input  logic [DW-1:0]     mem_rdata
);
  import xcopy_pkg::*;

  localparam int CW = PAGE_W + 1;

  xc_state_e      state;
  logic [AW-1:0]  src_q, dst_q;
  logic [LW-1:0]  rem_q;
  logic [SPW-1:0] src_sp_q, dst_sp_q;
  logic [1:0]     mode_q;
  logic [CW-1:0]  chunk_q, idx_q;

  logic           idle;
  logic [1:0]     wrap_mode;
  logic [AW-1:0]  src_raw, dst_raw, src_fold, dst_fold;
  logic [CW-1:0]  calc_chunk;
  logic           calc_burst;
  logic           last_beat;
  logic [CW-1:0]  rd_ptr;

  assign idle      = (state == ST_IDLE);
  assign wrap_mode = idle ? addr_mode : mode_q;
  assign src_raw   = idle ? src_addr : src_q + {{(AW-CW){1'b0}}, chunk_q};
  assign dst_raw   = idle ? dst_addr : dst_q + {{(AW-CW){1'b0}}, chunk_q};
  assign last_beat = (idx_q == chunk_q - CW'(1));

  // Fold the next step's addresses into the active mode.
  xcopy_addr_wrap #(.AW(AW)) u_wrap_src (
    .mode(wrap_mode), .addr_in(src_raw), .addr_out(src_fold));
  xcopy_addr_wrap #(.AW(AW)) u_wrap_dst (
    .mode(wrap_mode), .addr_in(dst_raw), .addr_out(dst_fold));

  xcopy_chunk_calc #(.LW(LW), .PAGE_W(PAGE_W)) u_chunk (
    .rem(rem_q),
    .src_off(src_q[PAGE_W-1:0]),
    .dst_off(dst_q[PAGE_W-1:0]),
    .src_ok(src_mapped),
    .dst_ok(dst_mapped),
    .chunk(calc_chunk),
    .burst(calc_burst)
  );

  // Read pointer runs one ahead of the accepted write beat.
  always_comb begin
    if (state == ST_WPREP)                 rd_ptr = '0;
    else if (state == ST_WRITE && mem_gnt) rd_ptr = idx_q + CW'(1);
    else                                   rd_ptr = idx_q;
  end

  xcopy_stage_buf #(.DW(DW), .ADDR_W(PAGE_W)) u_buf (
    .clk(clk),
    .wr_en(state == ST_READ && mem_gnt),
    .wr_addr(idx_q[PAGE_W-1:0]),
    .wr_data(mem_rdata),
    .rd_addr(rd_ptr[PAGE_W-1:0]),
    .rd_data(mem_wdata)
  );

  assign src_look_addr  = src_q;
  assign dst_look_addr  = dst_q;
  assign src_look_space = src_sp_q;
  assign dst_look_space = dst_sp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      src_q     <= '0;
      dst_q     <= '0;
      rem_q     <= '0;
      src_sp_q  <= '0;
      dst_sp_q  <= '0;
      mode_q    <= '0;
      chunk_q   <= '0;
      idx_q     <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      look_en   <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_space <= '0;
      mem_len   <= '0;
      mem_burst <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (length == '0) begin
              done <= 1'b1;
            end else begin
              src_q    <= src_fold;
              dst_q    <= dst_fold;
              rem_q    <= length;
              src_sp_q <= src_space;
              dst_sp_q <= dst_space;
              mode_q   <= addr_mode;
              busy     <= 1'b1;
              look_en  <= 1'b1;
              state    <= ST_LOOK;
            end
          end
        end
        ST_LOOK: begin
          look_en   <= 1'b0;
          chunk_q   <= calc_chunk;
          mem_len   <= calc_chunk;
          mem_burst <= calc_burst;
          idx_q     <= '0;
          mem_req   <= 1'b1;
          mem_we    <= 1'b0;
          mem_addr  <= src_q;
          mem_space <= src_sp_q;
          state     <= ST_READ;
        end
        ST_READ: begin
          if (mem_gnt) begin
            if (last_beat) begin
              mem_req <= 1'b0;
              state   <= ST_WPREP;
            end else begin
              idx_q    <= idx_q + CW'(1);
              mem_addr <= mem_addr + AW'(1);
            end
          end
        end
        ST_WPREP: begin
          idx_q     <= '0;
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= dst_q;
          mem_space <= dst_sp_q;
          state     <= ST_WRITE;
        end
        ST_WRITE: begin
          if (mem_gnt) begin
            if (last_beat) begin
              mem_req <= 1'b0;
              mem_we  <= 1'b0;
              rem_q   <= rem_q - {{(LW-CW){1'b0}}, chunk_q};
              src_q   <= src_fold;
              dst_q   <= dst_fold;
              if (rem_q == {{(LW-CW){1'b0}}, chunk_q}) begin
                busy  <= 1'b0;
                done  <= 1'b1;
                state <= ST_IDLE;
              end else begin
                look_en <= 1'b1;
                state   <= ST_LOOK;
              end
            end else begin
              idx_q    <= idx_q + CW'(1);
              mem_addr <= mem_addr + AW'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: 24-bit mode keeps beat addresses below 2^24
  a_r1_addr24: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mode_q == MODE_A24) |-> (mem_addr[AW-1:24] == '0));

  // R2: 31-bit mode keeps beat addresses below 2^31
  a_r2_addr31: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mode_q == MODE_A31) |-> (mem_addr[AW-1:31] == '0));

  // R4: a burst never steps into a new page
  a_r4_no_page_cross: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_gnt && !last_beat) |=> (mem_addr[PAGE_W-1:0] != '0));

  // R5: a non-burst step is a single beat
  a_r5_single_beat: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_burst) |-> (mem_len == CW'(1)));

  // R6: read beats use the source space, write beats the destination space
  a_r6_read_space: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |-> (mem_space == src_sp_q));
  a_r6_write_space: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_space == dst_sp_q));

  // R7: done is a one-cycle pulse and never overlaps busy
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R8: zero length completes next cycle without a request
  a_r8_zero_len: assert property (@(posedge clk) disable iff (rst)
    (idle && start && length == '0) |=> (done && !mem_req && !look_en));

  // R10: a start during a copy leaves the latched spaces alone
  a_r10_busy_start: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(src_sp_q) && $stable(dst_sp_q)));

endmodule

// File: tb/xspace_copy_engine_tb.sv
module xspace_copy_engine_tb;

  localparam int AW = 64;
  localparam int LW = 32;
  localparam int PW = 12;
  localparam int MB = 14;

  typedef struct packed {
    logic        we;
    logic [1:0]  sp;
    logic [63:0] a;
    logic [12:0] n;
    logic        b;
  } beat_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          start = 1'b0;
  logic [AW-1:0] src_addr = '0, dst_addr = '0;
  logic [LW-1:0] length = '0;
  logic [1:0]    src_space = '0, dst_space = '0, addr_mode = '0;
  logic          busy, done, look_en;
  logic [AW-1:0] src_look_addr, dst_look_addr;
  logic [1:0]    src_look_space, dst_look_space;
  logic          src_mapped, dst_mapped;
  logic          mem_req, mem_we, mem_burst;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_space;
  logic [12:0]   mem_len;
  logic [7:0]    mem_wdata, mem_rdata;
  logic          mem_gnt = 1'b0;

  int src_sel = 0, dst_sel = 0;
  logic [7:0] mem [4][1<<MB];
  logic [15:0] lfsr = 16'hACE1;

  beat_t got_q[$], exp_q[$];
  logic [127:0] look_got[$], look_exp[$];

  int checks = 0, errors = 0, cycles = 0;

  function automatic bit mapped_fn(logic [63:0] a, int sel);
    if (sel == 0) return 1'b1;
    if (sel == 1) return !a[12];
    return 1'b0;
  endfunction

  function automatic logic [63:0] fold(logic [63:0] a, logic [1:0] m);
    if (m == 2'd0) return a & 64'h0000_0000_00FF_FFFF;
    if (m == 2'd1) return a & 64'h0000_0000_7FFF_FFFF;
    return a;
  endfunction

  function automatic logic [7:0] pat(logic [1:0] sp, logic [MB-1:0] a);
    return a[7:0] ^ {a[13:8], 2'b01} ^ {6'd0, sp};
  endfunction

  assign src_mapped = mapped_fn(src_look_addr, src_sel);
  assign dst_mapped = mapped_fn(dst_look_addr, dst_sel);
  assign mem_rdata  = mem[mem_space][mem_addr[MB-1:0]];

  xspace_copy_engine u_dut (
    .clk(clk), .rst(rst), .start(start), .src_addr(src_addr), .dst_addr(dst_addr),
    .length(length), .src_space(src_space), .dst_space(dst_space), .addr_mode(addr_mode),
    .busy(busy), .done(done), .look_en(look_en),
    .src_look_addr(src_look_addr), .src_look_space(src_look_space), .src_mapped(src_mapped),
    .dst_look_addr(dst_look_addr), .dst_look_space(dst_look_space), .dst_mapped(dst_mapped),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_space(mem_space),
    .mem_len(mem_len), .mem_burst(mem_burst), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata));

  // Memory model and monitor: grant for the coming edge, then record that beat.
  always @(negedge clk) begin
    lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_gnt = lfsr[0] | lfsr[3];
    if (mem_req && mem_gnt) begin
      got_q.push_back({mem_we, mem_space, mem_addr, mem_len, mem_burst});
      if (mem_we) mem[mem_space][mem_addr[MB-1:0]] = mem_wdata;
    end
    if (look_en) begin
      look_got.push_back({src_look_addr, dst_look_addr});
      if (src_look_space != src_space || dst_look_space != dst_space) begin
        checks++; errors++;
        $display("FAIL R9 look spaces got %0d/%0d exp %0d/%0d",
                 src_look_space, dst_look_space, src_space, dst_space);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog got %0d cycles exp under 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] got,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", req, got, exp);
    end
  endtask

  task automatic init_mem();
    for (int s = 0; s < 4; s++)
      for (int a = 0; a < (1 << MB); a++) mem[s][a] = pat(2'(s), MB'(a));
  endtask

  task automatic build_expect(input logic [63:0] s, input logic [63:0] d,
                              input int len, input logic [1:0] ss,
                              input logic [1:0] ds, input logic [1:0] m);
    int rem = len;
    while (rem > 0) begin
      logic [63:0] ws = fold(s, m);
      logic [63:0] wd = fold(d, m);
      int c;
      bit b;
      look_exp.push_back({ws, wd});
      b = mapped_fn(ws, src_sel) && mapped_fn(wd, dst_sel);
      if (b) begin
        c = rem;
        if (4096 - int'(ws[11:0]) < c) c = 4096 - int'(ws[11:0]);
        if (4096 - int'(wd[11:0]) < c) c = 4096 - int'(wd[11:0]);
      end else c = 1;
      for (int i = 0; i < c; i++) exp_q.push_back({1'b0, ss, ws + 64'(i), 13'(c), b});
      for (int i = 0; i < c; i++) exp_q.push_back({1'b1, ds, wd + 64'(i), 13'(c), b});
      s = ws + 64'(c);
      d = wd + 64'(c);
      rem -= c;
    end
  endtask

  task automatic run_copy(input string req, input logic [63:0] s, input logic [63:0] d,
                          input int len, input logic [1:0] ss, input logic [1:0] ds,
                          input logic [1:0] m, input int ssel, input int dsel,
                          input bit poke);
    int n = 0;
    bit bad = 0;
    init_mem();
    got_q.delete(); exp_q.delete(); look_got.delete(); look_exp.delete();
    src_sel = ssel; dst_sel = dsel;
    build_expect(s, d, len, ss, ds, m);
    @(negedge clk);
    src_addr = s; dst_addr = d; length = LW'(len);
    src_space = ss; dst_space = ds; addr_mode = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && n < 40000) begin
      @(negedge clk);
      n++;
      if (poke && n == 6) begin
        // R10: foreign start while busy, inputs restored next cycle
        start = 1'b1; length = 32'd3;
        @(negedge clk);
        start = 1'b0; length = LW'(len);
      end
    end
    check(done === 1'b1, {req, " done seen"}, 64'(done), 64'd1);
    check(busy === 1'b0, {req, " R7 busy low with done"}, 64'(busy), 64'd0);
    @(negedge clk);
    check(done === 1'b0, {req, " R7 done single pulse"}, 64'(done), 64'd0);
    check(got_q.size() == exp_q.size(), {req, " beat count"}, 64'(got_q.size()),
          64'(exp_q.size()));
    for (int i = 0; i < got_q.size() && i < exp_q.size() && !bad; i++)
      if (got_q[i] !== exp_q[i]) begin
        bad = 1;
        check(1'b0, {req, " beat sequence"}, got_q[i].a, exp_q[i].a);
      end
    if (!bad) check(1'b1, {req, " beat sequence"}, 0, 0);
    bad = 0;
    check(look_got.size() == look_exp.size(), {req, " R9 lookup count"},
          64'(look_got.size()), 64'(look_exp.size()));
    for (int i = 0; i < look_got.size() && i < look_exp.size() && !bad; i++)
      if (look_got[i] !== look_exp[i]) begin
        bad = 1;
        check(1'b0, {req, " R9 lookup addr"}, look_got[i][127:64], look_exp[i][127:64]);
      end
    bad = 0;
    for (int i = 0; i < len && !bad; i++) begin
      logic [63:0] ws = fold(s + 64'(i), m);
      logic [63:0] wd = fold(d + 64'(i), m);
      if (mem[ds][wd[MB-1:0]] !== pat(ss, ws[MB-1:0])) begin
        bad = 1;
        check(1'b0, {req, " R7 data"}, 64'(mem[ds][wd[MB-1:0]]), 64'(pat(ss, ws[MB-1:0])));
      end
    end
    if (!bad) check(1'b1, {req, " R7 data"}, 0, 0);
  endtask

  task automatic test_reset();
    check(busy === 1'b0 && done === 1'b0, "reset busy/done", {busy, done}, 0);
    check(mem_req === 1'b0 && look_en === 1'b0, "reset req/look", {mem_req, look_en}, 0);
  endtask

  task automatic test_zero_len();
    got_q.delete(); look_got.delete();
    @(negedge clk);
    src_addr = 64'h100; dst_addr = 64'h200; length = '0; addr_mode = 2'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done === 1'b1, "R8 done next cycle", 64'(done), 1);
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R8 done pulse", {done, busy}, 0);
    check(got_q.size() == 0 && look_got.size() == 0, "R8 no access",
          64'(got_q.size()), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    test_reset();
    test_zero_len();
    run_copy("R4 R6 small burst",   64'h0000_0040, 64'h0000_0100, 20, 2'd0, 2'd2, 2'd2, 0, 0, 0);
    run_copy("R4 page clip",        64'h0000_0FF0, 64'h0000_1FF8, 40, 2'd1, 2'd3, 2'd2, 0, 0, 0);
    run_copy("R4 long copy",        64'h0000_0100, 64'h0000_2300, 5000, 2'd3, 2'd0, 2'd3, 0, 0, 0);
    run_copy("R5 src unmapped",     64'h0000_0FFC, 64'h0000_0300, 10, 2'd0, 2'd1, 2'd2, 1, 0, 0);
    run_copy("R5 dst unmapped",     64'h0000_0500, 64'h0000_0800, 6, 2'd2, 2'd1, 2'd2, 0, 2, 0);
    run_copy("R1 wrap 24",          64'hAB00_0000_00FF_FFF8, 64'h0000_0000_0000_0600, 16,
             2'd0, 2'd2, 2'd0, 0, 0, 0);
    run_copy("R2 wrap 31",          64'h0000_0001_7FFF_FFFC, 64'hFF00_0000_0000_0700, 8,
             2'd1, 2'd3, 2'd1, 0, 0, 0);
    run_copy("R3 64 passthrough",   64'hFFFF_0000_0000_0100, 64'h8000_0000_0000_0900, 12,
             2'd2, 2'd0, 2'd2, 0, 0, 0);
    run_copy("R10 start while busy", 64'h0000_0A00, 64'h0000_0C00, 30, 2'd0, 2'd3, 2'd2, 1, 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule